// File: doc/BRIEF.md
# DCT-Identity Dictionary Coefficient Generator

This block feeds a bank of parallel multiply-accumulate lanes with the entries of a dictionary of M rows and 2M columns. The left half of the dictionary is the orthonormal type-II cosine transform matrix. The right half is the M×M identity. The full matrix is never stored. The block keeps a single table of M scaled cosine samples. For each lane it works out the table address and sign from the row and column indices, folding the phase into one quadrant. The identity half comes from an index compare alone, with no storage.

All lanes share one vector element per cycle, and each lane receives a different dictionary entry. In forward mode the input index names a dictionary column. Lane p then works on row (base + p) mod M, which suits a product of the dictionary with x. In transpose mode the input index names a row. Lane p then works on column (base + p) mod 2M, which suits a product of the transpose with r. Rows and columns count from 0. Coefficients are signed fixed point with W−2 fractional bits, where W is the coefficient width, so 1.0 is 2^(W−2).

Top module: `dict_coef_gen`

## Requirements
- R1: While reset is low, and on the first cycle after it, out_valid is 0.
- R2: out_valid rises exactly two rising clock edges after a cycle with in_valid high, and stays low two edges after a cycle with in_valid low. Back-to-back requests give back-to-back results in order.
- R3: In forward mode (in_mode = 0), lane p presents the dictionary entry at row (in_base + p) mod M and column in_idx.
- R4: In transpose mode (in_mode = 1), lane p presents the dictionary entry at row in_idx and column (in_base + p) mod 2M.
- R5: For a column c < M and a row k ≥ 1, the entry is sqrt(2/M)·cos(π(2c+1)k/(2M))·2^(W−2), rounded to within one least significant bit, and it takes both signs as the cosine does.
- R6: Row 0 gives the same positive constant sqrt(1/M)·2^(W−2) for every column c < M.
- R7: For a column c ≥ M, the entry is exactly 2^(W−2) when the row equals c − M, and exactly 0 otherwise.
- R8: Lane indices wrap: forward-mode rows wrap modulo M, and transpose-mode columns wrap modulo 2M, crossing between the cosine and identity halves when needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe for this cycle |
| in_mode | input | 1 | 0 = forward (index is a column), 1 = transpose (index is a row) |
| in_idx | input | log2(2M) | Shared column (forward) or row (transpose) index |
| in_base | input | log2(2M) | Index of lane 0 along the lane dimension |
| out_valid | output | 1 | Coefficients valid, two edges after the request |
| out_coef | output | P·W | Lane p coefficient in bits [p·W +: W], signed |

## Verification
Every request turns into coefficients and a valid flag two rising edges later, because one register stage holds the folded indices and one holds the selected coefficient. The bench changes inputs on falling edges. A one-shot probe samples on the second falling edge after it drives a request, and also checks that the valid flag is low one edge early and one edge late. The streaming scenario drives a new request every cycle and, on each falling edge, checks the result of the request issued two cycles before. The expected values come from the cosine formula evaluated directly per lane, with no quadrant folding, so the folding logic is checked against an unrelated computation.

// File: rtl/dict_pkg.sv
// Shared definitions for the dictionary coefficient generator.
// Assumes the caller passes a power-of-two M and a fractional width that
// keeps every scaled value inside the coefficient width.
package dict_pkg;

    localparam real DICT_PI = 3.14159265358979323846;

    typedef enum logic {
        MODE_FWD = 1'b0,
        MODE_TRN = 1'b1
    } dict_mode_e;

    // Scaled cosine sample: sqrt(s/M)*cos(pi*a/(2M))*2^frac, s=1 for the first row
    function automatic int coef_value(int a, int m, int frac, bit first_row);
        real s;
        real v;
        s = first_row ? 1.0 : 2.0;
        v = $sqrt(s / real'(m)) * $cos(DICT_PI * real'(a) / (2.0 * real'(m)))
            * real'(longint'(1) << frac);
        return $rtoi(v + 0.5);
    endfunction

endpackage

// File: rtl/dict_phase_fold.sv
// Index arithmetic for one lane: turns a (row, column) pair into a cosine
// table address, a sign and flags for the identity half and for row 0.
// Assumes M is a power of two, so the phase wraps modulo 4M by truncation.
module dict_phase_fold #(
    parameter int M = 512
) (
    input  logic [$clog2(M)-1:0]   row,
    input  logic [$clog2(M):0]     col,
    output logic                   is_ident,
    output logic                   ident_hit,
    output logic                   row0,
    output logic                   neg,
    output logic                   zero,
    output logic [$clog2(M)-1:0]   addr
);
    localparam int LOGM  = $clog2(M);
    localparam int LOG4M = LOGM + 2;

    logic [LOGM-1:0]  col_low;
    logic [LOG4M-1:0] odd;
    logic [LOG4M-1:0] phase;
    logic [1:0]       quad;
    logic [LOGM-1:0]  frac;

    // Phase (2c+1)*k modulo 4M, folded into one quadrant of the table
    always_comb begin
        col_low   = col[LOGM-1:0];
        odd       = {1'b0, col_low, 1'b1};
        phase     = odd * LOG4M'(row);
        quad      = phase[LOG4M-1:LOG4M-2];
        frac      = phase[LOGM-1:0];
        addr      = quad[0] ? (LOGM'(0) - frac) : frac;
        zero      = quad[0] && (frac == '0);
        neg       = (quad == 2'd1) || (quad == 2'd2);
        is_ident  = col[LOGM];
        ident_hit = (row == col_low);
        row0      = (row == '0);
    end
endmodule

// File: rtl/dict_cos_rom.sv
// Table of M scaled cosine samples over the first quadrant, with one read
// port per lane. The contents are computed at build time from the formula.
// Assumes the fractional width gives values that fit COEF_W signed bits.
module dict_cos_rom #(
    parameter int M      = 512,
    parameter int P      = 4,
    parameter int COEF_W = 16
) (
    input  logic [P-1:0][$clog2(M)-1:0]   rd_addr,
    output logic [P-1:0][COEF_W-1:0]      rd_data
);
    localparam int FRAC = COEF_W - 2;

    logic [COEF_W-1:0] tbl [M];

    // Fill every table word from the closed-form sample value
    for (genvar a = 0; a < M; a++) begin : g_fill
        assign tbl[a] = COEF_W'(dict_pkg::coef_value(a, M, FRAC, 1'b0));
    end

    // One independent read port for each lane
    for (genvar p = 0; p < P; p++) begin : g_port
        assign rd_data[p] = tbl[rd_addr[p]];
    end
endmodule

// File: rtl/dict_lane.sv
// One output lane: registers the folded index fields, then picks the
// coefficient (table value, its negation, row-0 constant, identity value or
// zero) into the output register. The table read sits between the stages.
module dict_lane #(
    parameter int M      = 512,
    parameter int COEF_W = 16
) (
    input  logic                       clk,
    input  logic                       f_ident,
    input  logic                       f_hit,
    input  logic                       f_row0,
    input  logic                       f_neg,
    input  logic                       f_zero,
    input  logic [$clog2(M)-1:0]       f_addr,
    output logic [$clog2(M)-1:0]       rom_addr,
    input  logic [COEF_W-1:0]          rom_data,
    output logic [COEF_W-1:0]          coef
);
    localparam int LOGM = $clog2(M);
    localparam int FRAC = COEF_W - 2;
    localparam logic [COEF_W-1:0] ONE_VAL  = COEF_W'(1) << FRAC;
    localparam logic [COEF_W-1:0] ROW0_VAL =
        COEF_W'(dict_pkg::coef_value(0, M, FRAC, 1'b1));

    typedef struct packed {
        logic            ident;
        logic            hit;
        logic            row0;
        logic            neg;
        logic            zero;
        logic [LOGM-1:0] addr;
    } stage_t;

    stage_t            st;
    logic [COEF_W-1:0] pick;

    // Stage 1: hold the folded fields for the table read
    always_ff @(posedge clk) begin
        st <= '{ident: f_ident, hit: f_hit, row0: f_row0,
                neg: f_neg, zero: f_zero, addr: f_addr};
    end

    assign rom_addr = st.addr;

    // Select the coefficient source for this lane
    always_comb begin
        if (st.ident)
            pick = st.hit ? ONE_VAL : '0;
        else if (st.row0)
            pick = ROW0_VAL;
        else if (st.zero)
            pick = '0;
        else if (st.neg)
            pick = COEF_W'(0) - rom_data;
        else
            pick = rom_data;
    end

    // Stage 2: register the lane output
    always_ff @(posedge clk) begin
        coef <= pick;
    end
endmodule

// File: rtl/dict_coef_gen.sv
// Dictionary coefficient generator for P multiply-accumulate lanes over the
// M x 2M matrix [cosine transform | identity]. Forward mode: the index is a
// column and lane p takes row (base+p) mod M. Transpose mode: the index is a
// row and lane p takes column (base+p) mod 2M. Two-cycle latency.
// Assumes M is a power of two and P <= M.
module dict_coef_gen #(
    parameter int M      = 512,
    parameter int P      = 4,
    parameter int COEF_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_mode,
    input  logic [$clog2(2*M)-1:0]      in_idx,
    input  logic [$clog2(2*M)-1:0]      in_base,
    output logic                        out_valid,
    output logic [P*COEF_W-1:0]         out_coef
);
    localparam int LOGM  = $clog2(M);
    localparam int LOG2M = LOGM + 1;

    logic                          s1_valid;
    logic [P-1:0][LOGM-1:0]        rom_addr;
    logic [P-1:0][COEF_W-1:0]      rom_data;

    // Valid pipeline matching the two data stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
        end
    end

    dict_cos_rom #(.M(M), .P(P), .COEF_W(COEF_W)) u_rom (
        .rd_addr (rom_addr),
        .rd_data (rom_data)
    );

    for (genvar gp = 0; gp < P; gp++) begin : g_lane
        logic [LOGM-1:0]  row;
        logic [LOG2M-1:0] col;
        logic f_ident, f_hit, f_row0, f_neg, f_zero;
        logic [LOGM-1:0]  f_addr;

        // Map the shared index and this lane's offset to a row and column
        always_comb begin
            if (in_mode == dict_pkg::MODE_TRN) begin
                row = in_idx[LOGM-1:0];
                col = in_base + LOG2M'(gp);
            end else begin
                row = in_base[LOGM-1:0] + LOGM'(gp);
                col = in_idx;
            end
        end

        dict_phase_fold #(.M(M)) u_fold (
            .row       (row),
            .col       (col),
            .is_ident  (f_ident),
            .ident_hit (f_hit),
            .row0      (f_row0),
            .neg       (f_neg),
            .zero      (f_zero),
            .addr      (f_addr)
        );

        dict_lane #(.M(M), .COEF_W(COEF_W)) u_lane (
            .clk      (clk),
            .f_ident  (f_ident),
            .f_hit    (f_hit),
            .f_row0   (f_row0),
            .f_neg    (f_neg),
            .f_zero   (f_zero),
            .f_addr   (f_addr),
            .rom_addr (rom_addr[gp]),
            .rom_data (rom_data[gp]),
            .coef     (out_coef[gp*COEF_W +: COEF_W])
        );
    end
endmodule

// File: rtl/dict_coef_gen_chk.sv
// Checker for dict_coef_gen: keeps its own two-deep copy of the requests
// and relates them to the outputs. Bound to every instance of the top.
module dict_coef_gen_chk #(
    parameter int M      = 512,
    parameter int P      = 4,
    parameter int COEF_W = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic                        in_mode,
    input logic [$clog2(2*M)-1:0]      in_idx,
    input logic [$clog2(2*M)-1:0]      in_base,
    input logic                        out_valid,
    input logic [P*COEF_W-1:0]         out_coef
);
    localparam int LOG2M = $clog2(2*M);
    localparam int FRAC  = COEF_W - 2;
    localparam logic [COEF_W-1:0] ONE_VAL  = COEF_W'(1) << FRAC;
    localparam logic [COEF_W-1:0] ROW0_VAL =
        COEF_W'(dict_pkg::coef_value(0, M, FRAC, 1'b1));

    logic             v1, v2;
    logic             m1, m2;
    logic [LOG2M-1:0] i1, i2, b1, b2;

    // Delayed copy of the request, two cycles deep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
        end
        m1 <= in_mode;  m2 <= m1;
        i1 <= in_idx;   i2 <= i1;
        b1 <= in_base;  b2 <= b1;
    end

    logic [P-1:0] is_one, is_zero, r0_ok, id_ok;

    // Per-lane observations of the output against the delayed request
    for (genvar p = 0; p < P; p++) begin : g_obs
        logic [COEF_W-1:0] c;
        logic [LOG2M-1:0]  lane_col;
        assign c          = out_coef[p*COEF_W +: COEF_W];
        assign lane_col   = b2 + LOG2M'(p);
        assign is_one[p]  = (c == ONE_VAL);
        assign is_zero[p] = (c == '0);
        assign r0_ok[p]   = (int'(lane_col) >= M) || (c == ROW0_VAL);
        assign id_ok[p]   = (int'(lane_col) < M) ||
                            (c == ((int'(lane_col) - M == int'(i2)) ? ONE_VAL : '0));
    end

    // R1: reset keeps the output strobe low on the following cycle
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R2: a request produces a strobe two edges later
    a_r2_valid_due: assert property (@(posedge clk) disable iff (!rst_n)
        v2 |-> out_valid);

    // R2: no strobe without a request two edges earlier
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !v2 |-> !out_valid);

    // R7: forward request on an identity column gives at most one 1.0, rest 0
    a_r7_identity_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && !m2 && int'(i2) >= M) |-> ($onehot0(is_one) && ((is_one | is_zero) == '1)));

    // R6: transpose request on row 0 gives the flat constant on cosine columns
    a_r6_row0_flat: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && m2 && i2 == '0) |-> (&r0_ok));

    // R4: transpose request gives the diagonal pattern on identity columns
    a_r4_ident_trn: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && m2) |-> (&id_ok));
endmodule

bind dict_coef_gen dict_coef_gen_chk #(.M(M), .P(P), .COEF_W(COEF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_idx    (in_idx),
    .in_base   (in_base),
    .out_valid (out_valid),
    .out_coef  (out_coef)
);

// File: tb/dict_coef_gen_tb.sv
// Directed bench for dict_coef_gen: one task per scenario, each checking
// its own results against the closed-form dictionary entries.
module dict_coef_gen_tb;
    localparam int  M      = 16;
    localparam int  P      = 4;
    localparam int  COEF_W = 16;
    localparam int  LOG2M  = $clog2(2*M);
    localparam int  FRAC   = COEF_W - 2;
    localparam time CLK_PERIOD = 10ns;
    localparam real PI = 3.14159265358979323846;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic                   in_mode = 1'b0;
    logic [LOG2M-1:0]       in_idx = '0;
    logic [LOG2M-1:0]       in_base = '0;
    logic                   out_valid;
    logic [P*COEF_W-1:0]    out_coef;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dict_coef_gen #(.M(M), .P(P), .COEF_W(COEF_W)) u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_mode (in_mode),
        .in_idx (in_idx), .in_base (in_base),
        .out_valid (out_valid), .out_coef (out_coef)
    );

    // Reference entry straight from the dictionary definition
    function automatic int ref_entry(int row, int col);
        real v;
        if (col >= M) return (row == col - M) ? (1 << FRAC) : 0;
        v = $sqrt(((row == 0) ? 1.0 : 2.0) / M)
            * $cos(PI * real'((2*col + 1) * row) / (2.0 * M)) * real'(1 << FRAC);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    task automatic check_int(int act, int exp, int tol, string tag);
        int d;
        checks++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare all lanes against the reference for one request
    task automatic check_lanes(logic mode, int idx, int base, string tag);
        for (int p = 0; p < P; p++) begin
            int row, col, exp, act;
            if (mode) begin row = idx; col = (base + p) % (2*M); end
            else      begin row = (base + p) % M; col = idx; end
            exp = ref_entry(row, col);
            act = int'($signed(out_coef[p*COEF_W +: COEF_W]));
            check_int(act, exp, (col >= M) ? 0 : 1,
                      $sformatf("%s lane%0d row%0d col%0d", tag, p, row, col));
        end
    endtask

    // Single request; result sampled two edges later
    task automatic probe(logic mode, int idx, int base, string tag);
        @(negedge clk);
        in_valid = 1'b1; in_mode = mode;
        in_idx = LOG2M'(idx); in_base = LOG2M'(base);
        @(negedge clk);
        in_valid = 1'b0;
        check_int(int'(out_valid), 0, 0, {tag, " R2 early valid"});
        @(negedge clk);
        check_int(int'(out_valid), 1, 0, {tag, " R2 valid"});
        check_lanes(mode, idx, base, tag);
        @(negedge clk);
        check_int(int'(out_valid), 0, 0, {tag, " R2 late valid"});
    endtask

    task automatic t_reset;
        @(negedge clk);
        check_int(int'(out_valid), 0, 0, "R1 valid in reset");
        @(negedge clk);
        rst_n = 1'b1;
        check_int(int'(out_valid), 0, 0, "R1 valid after reset");
    endtask

    task automatic t_forward;
        for (int c = 0; c < M; c += 3) probe(1'b0, c, 0, "R3 R5 fwd");
        for (int c = 1; c < M; c += 5) probe(1'b0, c, 6, "R3 R5 fwd base6");
    endtask

    task automatic t_transpose;
        for (int k = 1; k < M; k += 3) probe(1'b1, k, 2, "R4 R5 trn");
        probe(1'b1, 7, 9, "R4 R5 trn base9");
    endtask

    task automatic t_row0;
        for (int b = 0; b < M; b += P) probe(1'b1, 0, b, "R6 row0");
        probe(1'b0, 11, 0, "R6 fwd row0 lane0");
    endtask

    task automatic t_identity;
        for (int c = M; c < 2*M; c += 3) probe(1'b0, c, 4, "R7 ident fwd");
        probe(1'b1, 3, M, "R7 ident trn diag");
        probe(1'b1, 9, M, "R7 ident trn off");
    endtask

    task automatic t_wrap;
        probe(1'b0, 5, M - 2, "R8 fwd wrap");
        probe(1'b0, M + 1, M - 2, "R8 fwd wrap ident");
        probe(1'b1, 1, 2*M - 2, "R8 trn wrap");
        probe(1'b1, 5, M - 2, "R8 trn cross");
    endtask

    // Back-to-back requests; each result checked two cycles after issue
    task automatic t_stream;
        localparam int N = 2*M;
        logic md [N];
        int   ix [N];
        int   bs [N];
        for (int i = 0; i < N; i++) begin
            md[i] = i[0];
            ix[i] = md[i] ? (i % M) : ((i * 7) % (2*M));
            bs[i] = (i * 5) % (2*M);
        end
        for (int i = 0; i < N + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check_int(int'(out_valid), 1, 0, "R2 stream valid");
                check_lanes(md[i-2], ix[i-2], bs[i-2], "R2 R3 R4 stream");
            end
            if (i < N) begin
                in_valid = 1'b1; in_mode = md[i];
                in_idx = LOG2M'(ix[i]); in_base = LOG2M'(bs[i]);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check_int(int'(out_valid), 0, 0, "R2 stream end");
    endtask

    bit done = 1'b0;

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_forward();
        t_transpose();
        t_row0();
        t_identity();
        t_wrap();
        t_stream();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule